// File: doc/BRIEF.md
# Serial Calendar Access Port

This block sits between a four-wire host port and a BCD calendar counter. The port has a chip enable, a serial clock, a direction select and a data line whose driver is split into a data output and an output-enable. Each host pin is brought into the system clock domain through a synchronizer, and all edges are detected in that domain.

A session begins when chip enable rises. The level of the select at that moment fixes the session type for the rest of the session. A low select starts a read session. The whole calendar value is captured into a shift register, and its first bit appears on the data line at once. The register then moves one bit per falling serial-clock edge. A high select starts a write session. Counting is frozen while it lasts, and bits are taken on rising serial-clock edges. When chip enable falls, the received fields go to the counter as a one-cycle load request. If the low-supply flag is set at capture time, a warning pattern is read out in place of the time.

Top module: `rtc_serial_port`

## Requirements
- R1: After reset, sdio_oe_o, freeze_o and load_o are 0 and all ld_*_o fields are 0.
- R2: sdio_oe_o goes to 1 within 6 system clocks after ce_i rises while dir_i is 0. It returns to 0 within 6 system clocks after ce_i falls. It stays 0 for the whole of a write session (dir_i 1 at the ce_i rise).
- R3: At the ce_i rise of a read session, time_i is captured. Within 6 clocks sdio_o shows time_i bit 0. Later changes of time_i do not alter the bits read in that session.
- R4: In a read session, each falling sclk_i edge presents the next captured bit. The bits come out in the order time_i[0] to time_i[51], where year is [7:0], month [15:8], date [23:16], day of week [27:24], hour [35:28], minute [43:36] and second [51:44].
- R5: After 52 falling sclk_i edges in a read session, further falling edges shift out 0.
- R6: If low_supply_i is 1 at the capture, each of the 13 nibbles reads as hex E. Per nibble, the bits read are 0,1,1,1 in time order.
- R7: In a write session, sdio_i is sampled on each rising sclk_i edge. Only the last 44 bits are kept. The first of those 44 bits is the year LSB, and the layout is the same as bits [43:0] of R4.
- R8: When ce_i falls to end a write session, load_o pulses high for exactly one clock. In that same cycle ld_*_o carry the received fields, and they change at no other time.
- R9: freeze_o is 1 from the start of a write session until the cycle of its load_o pulse, and 0 outside write sessions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Host chip enable |
| sclk_i | input | 1 | Host serial clock |
| dir_i | input | 1 | Direction select: 1 host writes, 0 host reads |
| sdio_i | input | 1 | Serial data from host |
| sdio_o | output | 1 | Serial data to host |
| sdio_oe_o | output | 1 | Enable for the data pin driver |
| low_supply_i | input | 1 | Low-supply warning flag |
| time_i | input | 52 | Current calendar value, layout as in R4 |
| freeze_o | output | 1 | Stop counting and hold the prescaler clear |
| load_o | output | 1 | One-cycle counter load request |
| ld_year_o | output | 8 | Year to load |
| ld_month_o | output | 8 | Month to load |
| ld_date_o | output | 8 | Date to load |
| ld_dow_o | output | 4 | Day of week to load |
| ld_hour_o | output | 8 | Hour to load |
| ld_minute_o | output | 8 | Minute to load |

## Verification
The assertions take for granted that every host pin holds each level for several system clocks. A short pulse would be lost in the synchronizers, and the fixed three-cycle link between ce_i and the data-pin enable would no longer hold. They also assume that dir_i is settled before chip enable rises, and that sdio_i does not change across a rising serial-clock edge. The stimulus holds every serial-clock phase for four system clocks. It sets dir_i and the data bit a full phase ahead of the edge that uses them, and it waits six clocks after each chip-enable change.

// File: rtl/rtc_sio_pkg.sv
package rtc_sio_pkg;
  localparam int DIG_W  = 4;
  localparam int BYTE_W = 8;
  localparam int RD_W   = 52;
  localparam int WR_W   = 44;
  localparam int NIB_N  = RD_W / DIG_W;

  typedef enum logic [1:0] {SES_IDLE, SES_READ, SES_WRITE} ses_e;

  function automatic logic [RD_W-1:0] warn_word();
    logic [RD_W-1:0] w;
    for (int n = 0; n < NIB_N; n++) w[n*DIG_W +: DIG_W] = 4'hE;
    return w;
  endfunction
endpackage

// File: rtl/rtc_sio_sync.sv
module rtc_sio_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rtc_sio_edge.sv
module rtc_sio_edge #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= '0;
    else         d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
  assign fall_o = ~d_i & d_q;
endmodule

// File: rtl/rtc_sio_shreg.sv
module rtc_sio_shreg
  import rtc_sio_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  logic [RD_W-1:0] cap_data_i,
  input  logic            clr_i,
  input  logic            rd_shift_i,
  input  logic            wr_shift_i,
  input  logic            din_i,
  output logic [RD_W-1:0] q_o
);
  logic [RD_W-1:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr <= '0;
    else if (cap_i)      sr <= cap_data_i;
    else if (clr_i)      sr <= '0;
    else if (rd_shift_i) sr <= sr >> 1;
    else if (wr_shift_i) sr <= {{(RD_W-WR_W){1'b0}}, din_i, sr[WR_W-1:1]};
  end

  assign q_o = sr;
endmodule

// File: rtl/rtc_serial_port.sv
module rtc_serial_port
  import rtc_sio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              sclk_i,
  input  logic              dir_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  input  logic              low_supply_i,
  input  logic [RD_W-1:0]   time_i,
  output logic              freeze_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] ld_year_o,
  output logic [BYTE_W-1:0] ld_month_o,
  output logic [BYTE_W-1:0] ld_date_o,
  output logic [DIG_W-1:0]  ld_dow_o,
  output logic [BYTE_W-1:0] ld_hour_o,
  output logic [BYTE_W-1:0] ld_minute_o
);
  localparam logic [RD_W-1:0] WARN = warn_word();

  logic [3:0] pins_s;
  logic       ce_s, sclk_s, dir_s, din_s;
  logic [1:0] rise, fall;
  logic       ce_rise, ce_fall, sclk_rise, sclk_fall;
  ses_e       ses_q;
  logic [RD_W-1:0] sr;

  rtc_sio_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdio_i, dir_i, sclk_i, ce_i}),
    .q_o   (pins_s)
  );
  assign {din_s, dir_s, sclk_s, ce_s} = pins_s;

  rtc_sio_edge #(.W(2)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_s, ce_s}),
    .rise_o(rise),
    .fall_o(fall)
  );
  assign {sclk_rise, ce_rise} = rise;
  assign {sclk_fall, ce_fall} = fall;

  // session type is fixed by the select level at the chip-enable rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ses_q <= SES_IDLE;
    else if (ce_rise) ses_q <= dir_s ? SES_WRITE : SES_READ;
    else if (ce_fall) ses_q <= SES_IDLE;
  end

  rtc_sio_shreg u_sr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (ce_rise & ~dir_s),
    .cap_data_i(low_supply_i ? WARN : time_i),
    .clr_i     (ce_rise & dir_s),
    .rd_shift_i((ses_q == SES_READ) & sclk_fall),
    .wr_shift_i((ses_q == SES_WRITE) & sclk_rise),
    .din_i     (din_s),
    .q_o       (sr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o      <= 1'b0;
      ld_year_o   <= '0;
      ld_month_o  <= '0;
      ld_date_o   <= '0;
      ld_dow_o    <= '0;
      ld_hour_o   <= '0;
      ld_minute_o <= '0;
    end else begin
      load_o <= (ses_q == SES_WRITE) & ce_fall;
      if ((ses_q == SES_WRITE) & ce_fall) begin
        ld_year_o   <= sr[7:0];
        ld_month_o  <= sr[15:8];
        ld_date_o   <= sr[23:16];
        ld_dow_o    <= sr[27:24];
        ld_hour_o   <= sr[35:28];
        ld_minute_o <= sr[43:36];
      end
    end
  end

  assign sdio_oe_o = (ses_q == SES_READ);
  assign sdio_o    = sr[0] & sdio_oe_o;
  assign freeze_o  = (ses_q == SES_WRITE);
endmodule

// File: rtl/rtc_sio_chk.sv
module rtc_sio_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_i,
  input logic       sdio_oe_o,
  input logic       freeze_o,
  input logic       load_o,
  input logic [7:0] ld_minute_o,
  input logic [7:0] ld_year_o
);
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o); // R8
  AST_LOAD_ENDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> ($past(freeze_o) && !freeze_o)); // R9
  AST_OE_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> $past(ce_i, 3)); // R2
  AST_MODES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdio_oe_o && freeze_o)); // R2
  AST_FIELDS_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ld_minute_o) || !$stable(ld_year_o)) |-> load_o); // R8
endmodule

bind rtc_serial_port rtc_sio_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_i       (ce_i),
  .sdio_oe_o  (sdio_oe_o),
  .freeze_o   (freeze_o),
  .load_o     (load_o),
  .ld_minute_o(ld_minute_o),
  .ld_year_o  (ld_year_o)
);

// File: tb/rtc_serial_port_tb_top.sv
module rtc_serial_port_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce = 1'b0, sclk = 1'b0, dir = 1'b0, din = 1'b0, low = 1'b0;
  logic [51:0] tval = '0;
  logic sdo, oe, frz, ld;
  logic [7:0] y, mo, dt, hr, mi;
  logic [3:0] dw;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rtc_serial_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce), .sclk_i(sclk), .dir_i(dir),
    .sdio_i(din), .sdio_o(sdo), .sdio_oe_o(oe), .low_supply_i(low),
    .time_i(tval), .freeze_o(frz), .load_o(ld), .ld_year_o(y),
    .ld_month_o(mo), .ld_date_o(dt), .ld_dow_o(dw), .ld_hour_o(hr),
    .ld_minute_o(mi)
  );

  // {low_supply, time}
  localparam logic [52:0] RD_VEC [4] = '{
    {1'b0, 52'h59_30_12_3_31_12_99},
    {1'b0, 52'h00_00_00_1_01_01_00},
    {1'b1, 52'h45_07_23_7_28_02_24},
    {1'b0, 52'hA5_5A_C3_6_3C_96_0F}
  };
  localparam logic [51:0] WARN = 52'hE_EEEE_EEEE_EEEE;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [52:0] v);
    logic [51:0] exp;
    exp = v[52] ? WARN : v[51:0];
    dir = 1'b0; sclk = 1'b0; low = v[52]; tval = v[51:0];
    wait_clk(4);
    ce = 1'b1;
    wait_clk(6);
    tval = ~v[51:0];
    low = ~v[52];
    check(oe, 1, "R2 oe in read");
    check(frz, 0, "R9 no freeze in read");
    for (int i = 0; i < 60; i++) begin
      if (i == 0)       check(sdo, exp[0], "R3 first bit of snapshot");
      else if (i >= 52) check(sdo, 0, "R5 zero after 52");
      else if (v[52])   check(sdo, exp[i], "R6 warning bit");
      else              check(sdo, exp[i], "R4 read bit order");
      sclk = 1'b1; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
    end
    ce = 1'b0;
    wait_clk(6);
    check(oe, 0, "R2 oe off after ce low");
  endtask

  task automatic do_write(input logic [43:0] w, input logic [7:0] junk);
    int pulses;
    dir = 1'b1; sclk = 1'b0;
    wait_clk(4);
    ce = 1'b1;
    wait_clk(6);
    check(frz, 1, "R9 freeze in write");
    check(oe, 0, "R2 oe off in write");
    for (int i = 0; i < 52; i++) begin
      din = (i < 8) ? junk[i] : w[i-8];
      wait_clk(4);
      sclk = 1'b1; wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    check(ld, 0, "R8 no load before commit");
    check(frz, 1, "R9 freeze held until commit");
    ce = 1'b0;
    pulses = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (ld) begin
        pulses++;
        check(y,  w[7:0],   "R7 year field");
        check(mo, w[15:8],  "R7 month field");
        check(dt, w[23:16], "R7 date field");
        check(dw, w[27:24], "R7 dow field");
        check(hr, w[35:28], "R7 hour field");
        check(mi, w[43:36], "R7 minute field");
        check(frz, 0, "R9 freeze drops at load");
      end
    end
    check(pulses, 1, "R8 single load pulse");
    check(frz, 0, "R9 freeze off after session");
    dir = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(3);
    check(oe, 0, "R1 oe in reset");
    check(ld, 0, "R1 load in reset");
    rst_ni = 1'b1;
    wait_clk(3);
    check(frz, 0, "R1 freeze after reset");
    check({y, mo, dt, dw, hr, mi}, 0, "R1 fields after reset");
    check(oe, 0, "R2 oe idle");
    for (int n = 0; n < 4; n++) do_read(RD_VEC[n]);
    do_write(44'h30_12_3_31_12_99, 8'hFF);
    do_write(44'h07_23_7_28_02_24, 8'h5A);
    // fields hold between sessions; a read session must not load
    do_read({1'b0, 52'h11_22_13_4_15_06_07});
    check(mi, 8'h07, "R8 fields hold after read session");
    check(y, 8'h24, "R8 year held");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule